// File: doc/BRIEF.md
# Priority Interrupt Request Arbiter

This block collects interrupt requests from a set of devices (eight by default) and decides whether the processor should be interrupted. Each device gives three things: a ready flag, an interrupt-enable flag and a 3-bit urgency level. The processor supplies the 3-bit level of the program it is running. The arbiter finds the most urgent pending request. It reports that request only when its level is strictly above the running level.

The processor tests for an interrupt once per instruction, between the end of one instruction and the next fetch. It marks that point with a one-cycle boundary strobe. On a clock edge where the strobe is high, the arbiter registers its decision: a take-interrupt flag, plus the index and level of the winning device. Between strobes the registered decision holds. When the take flag is clear, the processor simply carries on. Requests are level-sensitive: a device stays a candidate for as long as it holds its flags set.

Top module: `prio_irq_arbiter`

## Requirements
- R1: While reset is high at a clock edge, the outputs become take=0, device=0, level=0 after that edge.
- R2: Device i takes part in arbitration only when both `dev_ready_i[i]` and `dev_ie_i[i]` are 1. A ready device with its enable cleared, or an enabled device that is not ready, never wins.
- R3: Among pending devices, the one with the numerically largest level wins. Device i's level is `dev_level_i[3*i+2 : 3*i]`, and 7 is the most urgent.
- R4: When several pending devices share the largest level, the lowest device index wins.
- R5: Take is 1 only when the winning level is strictly greater than `cpu_level_i`. A winner whose level is equal to or below the running level gives take=0.
- R6: The outputs are updated only on a clock edge where `boundary_i` is 1. That update uses the inputs present at that edge, and the outputs are valid from the following cycle. On all other edges the outputs keep their values.
- R7: Whenever take is 0, the device and level outputs are both 0.
- R8: A request is not latched. If a device drops its ready flag before a boundary, that boundary's decision does not report it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction-boundary strobe; the decision is captured on its edge |
| cpu_level_i | input | 3 | Level of the running program |
| dev_ready_i | input | 8 | Per-device ready flags |
| dev_ie_i | input | 8 | Per-device interrupt-enable flags |
| dev_level_i | input | 24 | Packed device levels, 3 bits per device, device 0 in the low bits |
| irq_take_o | output | 1 | Interrupt the processor |
| irq_dev_o | output | 3 | Index of the winning device |
| irq_level_o | output | 3 | Level of the winning device |

## Verification
Some properties hold on every cycle, and the assertions check those:
- the outputs hold between strobes;
- a clear take flag forces the device and level outputs to zero;
- any reported winner's level is strictly above the running level sampled at the strobe;
- the reported device was both ready and enabled at that strobe;
- reset clears the take flag.

Other behaviour can only be shown by the bench scenarios, because it depends on the whole set of requests. That covers the highest level winning over all other candidates, the lower index winning a tie, the equal-level refusal, and a dropped request disappearing from the next decision. The bench checks these against a scoreboard model.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int DEF_NUM_DEV = 8;
  localparam int DEF_LVL_W   = 3;

  function automatic int idx_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/irq_pending_mask.sv
module irq_pending_mask #(
  parameter int NUM_DEV = 8
) (
  input  logic [NUM_DEV-1:0] ready_i,
  input  logic [NUM_DEV-1:0] ie_i,
  output logic [NUM_DEV-1:0] pend_o
);
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign pend_o[g] = ready_i[g] & ie_i[g];
  end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_arb_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = idx_width(NUM_DEV)
) (
  input  logic [NUM_DEV-1:0]       pend_i,
  input  logic [NUM_DEV*LVL_W-1:0] level_i,
  output logic                     any_o,
  output logic [IDX_W-1:0]         idx_o,
  output logic [LVL_W-1:0]         lvl_o
);
  // Scan from the top index down; ">=" lets a lower index displace an equal level.
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (pend_i[i] && (!any_o || level_i[i*LVL_W +: LVL_W] >= lvl_o)) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        lvl_o = level_i[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_outrank_cmp.sv
module irq_outrank_cmp #(
  parameter int LVL_W = 3
) (
  input  logic             any_i,
  input  logic [LVL_W-1:0] win_lvl_i,
  input  logic [LVL_W-1:0] cpu_lvl_i,
  output logic             take_o
);
  assign take_o = any_i && (win_lvl_i > cpu_lvl_i);
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_DEV = DEF_NUM_DEV,
  parameter int LVL_W   = DEF_LVL_W,
  localparam int IDX_W  = idx_width(NUM_DEV)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     boundary_i,
  input  logic [LVL_W-1:0]         cpu_level_i,
  input  logic [NUM_DEV-1:0]       dev_ready_i,
  input  logic [NUM_DEV-1:0]       dev_ie_i,
  input  logic [NUM_DEV*LVL_W-1:0] dev_level_i,
  output logic                     irq_take_o,
  output logic [IDX_W-1:0]         irq_dev_o,
  output logic [LVL_W-1:0]         irq_level_o
);
  logic [NUM_DEV-1:0] pend;
  logic               any_pend;
  logic [IDX_W-1:0]   win_idx;
  logic [LVL_W-1:0]   win_lvl;
  logic               take;

  irq_pending_mask #(.NUM_DEV(NUM_DEV)) u_mask (
    .ready_i (dev_ready_i),
    .ie_i    (dev_ie_i),
    .pend_o  (pend)
  );

  irq_prio_select #(.NUM_DEV(NUM_DEV), .LVL_W(LVL_W)) u_sel (
    .pend_i  (pend),
    .level_i (dev_level_i),
    .any_o   (any_pend),
    .idx_o   (win_idx),
    .lvl_o   (win_lvl)
  );

  irq_outrank_cmp #(.LVL_W(LVL_W)) u_cmp (
    .any_i     (any_pend),
    .win_lvl_i (win_lvl),
    .cpu_lvl_i (cpu_level_i),
    .take_o    (take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_take_o  <= 1'b0;
      irq_dev_o   <= '0;
      irq_level_o <= '0;
    end else if (boundary_i) begin
      irq_take_o  <= take;
      irq_dev_o   <= take ? win_idx : '0;
      irq_level_o <= take ? win_lvl : '0;
    end
  end
endmodule

// File: rtl/prio_irq_arbiter_chk.sv
module prio_irq_arbiter_chk #(
  parameter int NUM_DEV = 8,
  parameter int LVL_W   = 3,
  parameter int IDX_W   = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     boundary_i,
  input logic [LVL_W-1:0]         cpu_level_i,
  input logic [NUM_DEV-1:0]       dev_ready_i,
  input logic [NUM_DEV-1:0]       dev_ie_i,
  input logic [NUM_DEV*LVL_W-1:0] dev_level_i,
  input logic                     irq_take_o,
  input logic [IDX_W-1:0]         irq_dev_o,
  input logic [LVL_W-1:0]         irq_level_o
);
  logic [NUM_DEV-1:0] both_q;
  always_ff @(posedge clk) both_q <= dev_ready_i & dev_ie_i;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !irq_take_o);

  a_r6_hold_off_boundary: assert property (@(posedge clk) disable iff (rst)
    !boundary_i |=> ($stable(irq_take_o) && $stable(irq_dev_o) && $stable(irq_level_o)));

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !irq_take_o |-> (irq_dev_o == '0 && irq_level_o == '0));

  a_r5_strictly_above: assert property (@(posedge clk) disable iff (rst)
    ($past(boundary_i) && irq_take_o) |-> (irq_level_o > $past(cpu_level_i)));

  a_r2_winner_pending: assert property (@(posedge clk) disable iff (rst)
    ($past(boundary_i) && irq_take_o) |-> both_q[irq_dev_o]);
endmodule

bind prio_irq_arbiter prio_irq_arbiter_chk #(
  .NUM_DEV(NUM_DEV), .LVL_W(LVL_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/tb_prio_irq_arbiter.sv
module tb_prio_irq_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int LW = 3;
  localparam int IW = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            boundary = 1'b0;
  logic [LW-1:0]   cpu_lvl = '0;
  logic [N-1:0]    ready = '0;
  logic [N-1:0]    ie = '0;
  logic [N*LW-1:0] lvls = '0;
  logic            take;
  logic [IW-1:0]   dev;
  logic [LW-1:0]   lvl;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic          take;
    logic [IW-1:0] dev;
    logic [LW-1:0] lvl;
    string         tag;
  } exp_t;
  exp_t sb_q[$];
  logic bnd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_arbiter dut (
    .clk(clk), .rst(rst), .boundary_i(boundary), .cpu_level_i(cpu_lvl),
    .dev_ready_i(ready), .dev_ie_i(ie), .dev_level_i(lvls),
    .irq_take_o(take), .irq_dev_o(dev), .irq_level_o(lvl)
  );

  // Model built from the requirements: walk levels from most urgent down,
  // take the first (lowest) index pending at that level.
  function automatic exp_t model(input string tag);
    exp_t e;
    e.take = 1'b0; e.dev = '0; e.lvl = '0; e.tag = tag;
    for (int l = (1 << LW) - 1; l >= 0; l--) begin
      for (int d = 0; d < N; d++) begin
        if (!e.take && ready[d] && ie[d] && int'(lvls[d*LW +: LW]) == l) begin
          if (l > int'(cpu_lvl)) begin
            e.take = 1'b1; e.dev = IW'(d); e.lvl = LW'(l);
          end
          l = -1;
          break;
        end
      end
    end
    return e;
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] ex);
    checks++;
    if (act !== ex) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, ex);
    end
  endtask

  // Driver: apply inputs, strobe one boundary, push the expected decision.
  task automatic drive(input string tag, input logic [N-1:0] r, input logic [N-1:0] e,
                       input logic [N*LW-1:0] lv, input logic [LW-1:0] c);
    @(negedge clk);
    ready = r; ie = e; lvls = lv; cpu_lvl = c; boundary = 1'b1;
    sb_q.push_back(model(tag));
    @(negedge clk);
    boundary = 1'b0;
  endtask

  always @(posedge clk) bnd_seen <= boundary;

  // Monitor: one cycle after each captured boundary, compare against the queue.
  always @(negedge clk) begin
    if (bnd_seen && !rst && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, {take, dev, lvl}, {e.take, e.dev, e.lvl});
    end
  end

  function automatic logic [N*LW-1:0] pack(input int l0, l1, l2, l3, l4, l5, l6, l7);
    return {LW'(l7), LW'(l6), LW'(l5), LW'(l4), LW'(l3), LW'(l2), LW'(l1), LW'(l0)};
  endfunction

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", {take, dev, lvl}, 7'd0);
    rst = 1'b0;

    // R3: the top level wins
    drive("R3 highest level", 8'hFF, 8'hFF, pack(1,2,6,3,0,4,5,2), 3'd0);
    // R4: a tie goes to the lower index
    drive("R4 tie lower index", 8'hFF, 8'hFF, pack(1,5,2,5,0,5,3,4), 3'd0);
    // R2: device 6 is ready but not enabled, device 5 is enabled but not ready
    drive("R2 masking", 8'b0101_1111, 8'b1011_1111, pack(1,1,2,1,1,7,7,3), 3'd0);
    // R5: the winner equal to the running level gives no interrupt
    drive("R5 equal no take", 8'h0F, 8'h0F, pack(2,4,4,1,0,0,0,0), 3'd4);
    drive("R5 one above takes", 8'h0F, 8'h0F, pack(2,4,5,1,0,0,0,0), 3'd4);
    drive("R5 lower no take R7", 8'h03, 8'h03, pack(1,2,0,0,0,0,0,0), 3'd6);
    drive("R3 level7 over cpu6", 8'h80, 8'h80, pack(0,0,0,0,0,0,0,7), 3'd6);
    drive("R7 nothing pending", 8'h00, 8'hFF, pack(7,7,7,7,7,7,7,7), 3'd0);

    // R8: a request the device drops before the next boundary disappears from that decision
    drive("R8 request present", 8'h04, 8'h04, pack(0,0,3,0,0,0,0,0), 3'd1);
    drive("R8 request dropped", 8'h00, 8'h04, pack(0,0,3,0,0,0,0,0), 3'd1);

    // R6: input changes without a strobe leave the outputs alone
    drive("R6 setup", 8'h02, 8'h02, pack(0,6,0,0,0,0,0,0), 3'd2);
    @(negedge clk);
    ready = 8'h80; ie = 8'h80; lvls = pack(0,0,0,0,0,0,0,7); cpu_lvl = 3'd0;
    repeat (3) @(negedge clk);
    check("R6 hold without strobe", {take, dev, lvl}, {1'b1, 3'd1, 3'd6});

    // Mixed patterns
    for (int k = 0; k < 40; k++) begin
      drive("R3 R4 R5 sweep", N'($urandom), N'($urandom), (N*LW)'({$urandom, $urandom}),
            LW'($urandom));
    end

    // R1: reset mid-run clears a pending take
    drive("R1 pre-reset take", 8'h01, 8'h01, pack(5,0,0,0,0,0,0,0), 3'd0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset clears", {take, dev, lvl}, 7'd0);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule